// File: doc/BRIEF.md
# Timer Tick Prescaler and Divider

This block turns one base clock into a set of per-channel tick enables for a five-channel pulse-width timer. It has two 8-bit prescale counters. Each one produces a single-cycle pulse once every (value + 1) base-clock cycles. The first prescaler feeds channels 0 and 1, and the second feeds channels 2, 3 and 4. A 4-bit selector per channel either divides its prescaled pulse train by a power of two or switches the channel to an asynchronous external clock. The external clock is synchronised and edge-detected, so each of its rising edges becomes one tick. No derived clocks leave the block: every output is an enable in the base-clock domain, and the downstream counters consume it.

Software supplies two words through write strobes, one with both prescale values and one with all the selectors. A write lands in a holding register. The active copy of a value changes only on a prescale boundary of the group that owns it, so a reconfiguration never produces a tick of partial length.

Each channel runs a two-state machine. CH_DIVIDE counts prescale pulses. CH_EXTERNAL forwards the edges of the external clock. The transition CH_DIVIDE→CH_EXTERNAL, and the transition back, happens only on a prescale pulse, and only when the pending selector names the other mode. Each synchroniser tracks the level of its input in two states, SY_LOW and SY_HIGH. The step SY_LOW→SY_HIGH is the edge that is reported as a tick.

Top module: `pwm_tick_gen`

## Requirements
- R1: While `rst_n` is low, every `tick_o` bit is 0. Reset clears both prescale values and all selectors to zero. With those settings, every channel ticks on every cycle after reset is released.
- R2: `pre_wdata` bits 7:0 set prescaler 0 and bits 15:8 set prescaler 1. A prescaler with value P emits one pulse every P+1 base cycles.
- R3: Channels 0 and 1 use prescaler 0 and external input `ext_clk_i[0]`. Channels 2 to 4 use prescaler 1 and `ext_clk_i[1]`.
- R4: The selector for channel c sits in bits 4c+3:4c of `sel_wdata`.
- R5: A selector code k in 0..MAX_DIV_CODE (default 4) that is not external makes the channel tick on every 2^(k+DIV_BASE)-th pulse of its prescaler (DIV_BASE defaults to 0). That tick appears one cycle after the prescale pulse, and no tick appears without one.
- R6: A code above MAX_DIV_CODE that is not external divides as if it were MAX_DIV_CODE. With the defaults, codes 8..15 divide by 16.
- R7: Codes whose bit is set in EXT_CODES (default codes 5, 6 and 7) make the channel emit one single-cycle tick per rising edge of its external input. The tick is high in the cycle after the third rising base-clock edge following the input's change, and two ticks are never adjacent.
- R8: A write to either word takes effect at the next pulse of the prescaler that owns the field. When a channel's active selector changes, its divide count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 2 | Asynchronous external clocks, bit g for group g |
| pre_wr | input | 1 | Write strobe for the prescale word |
| pre_wdata | input | 16 | Prescale values, 8 bits per group |
| sel_wr | input | 1 | Write strobe for the selector word |
| sel_wdata | input | 20 | Selector codes, 4 bits per channel |
| tick_o | output | 5 | Per-channel single-cycle tick enables |

## Verification
The hardest situation to reach is a write that arrives in the middle of a long prescale period while a channel is changing mode. Here the old divide count, the deferred selector and the restart of the count all interact on a single boundary cycle. The stimulus programs long prescale values, writes new selectors several cycles before the boundary, and also writes them on the boundary cycle itself. It moves channels into the external mode and back while both external inputs toggle with coprime half-periods. A behavioural model tracks pending and active values in plain integers and compares every output bit on every cycle.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

    typedef enum logic {
        CH_DIVIDE   = 1'b0,
        CH_EXTERNAL = 1'b1
    } ch_mode_e;

    typedef enum logic {
        SY_LOW  = 1'b0,
        SY_HIGH = 1'b1
    } sync_state_e;

    // Group that owns a channel: low channels go to group 0.
    function automatic int grp_of(input int ch, input int grp0_count);
        return (ch < grp0_count) ? 0 : 1;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [PRE_W-1:0] wdata,
    output logic             pre_tick,
    output logic [PRE_W-1:0] act_val
);

    logic [PRE_W-1:0] pend_q;
    logic [PRE_W-1:0] act_q;
    logic [PRE_W-1:0] cnt_q;

    assign pre_tick = (cnt_q == act_q);
    assign act_val  = act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (wr) begin
            pend_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            cnt_q <= '0;
        end else if (pre_tick) begin
            act_q <= pend_q;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_ext_sync.sv
module pwm_ext_sync
    import pwm_tick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic edge_o
);

    logic        meta_q;
    logic        sync_q;
    sync_state_e st_q;
    sync_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= ext_in;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SY_LOW:  if (sync_q)  st_d = SY_HIGH;
            SY_HIGH: if (!sync_q) st_d = SY_LOW;
            default: st_d = SY_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SY_LOW;
        else        st_q <= st_d;
    end

    assign edge_o = (st_q == SY_LOW) && sync_q;

endmodule

// File: rtl/pwm_tick_channel.sv
module pwm_tick_channel
    import pwm_tick_pkg::*;
#(
    parameter int                  SEL_W        = 4,
    parameter int                  DIV_BASE     = 0,
    parameter int                  MAX_DIV_CODE = 4,
    parameter logic [2**SEL_W-1:0] EXT_CODES    = 16'h00E0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] wdata,
    input  logic             pre_tick,
    input  logic             ext_edge,
    output logic             tick_o,
    output logic             is_ext,
    output logic [SEL_W-1:0] act_sel
);

    localparam int MAX_EXP = MAX_DIV_CODE + DIV_BASE;
    localparam int DCNT_W  = MAX_EXP + 1;

    logic [SEL_W-1:0]  pend_q;
    logic [SEL_W-1:0]  act_q;
    logic [DCNT_W-1:0] dcnt_q;
    logic [DCNT_W-1:0] mask;
    logic              hit;
    logic              sel_change;
    logic              tick_q;
    ch_mode_e          mode_q;
    ch_mode_e          mode_d;

    function automatic logic [DCNT_W-1:0] mask_of(input logic [SEL_W-1:0] code);
        int e;
        e = ((int'(code) > MAX_DIV_CODE) ? MAX_DIV_CODE : int'(code)) + DIV_BASE;
        return DCNT_W'((1 << e) - 1);
    endfunction

    assign mask       = mask_of(act_q);
    assign hit        = ((dcnt_q & mask) == mask);
    assign sel_change = (pend_q != act_q);

    // Holding register for the selector field.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pend_q <= '0;
        else if (wr) pend_q <= wdata;
    end

    // Active selector and divide count move only on a prescale pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            dcnt_q <= '0;
        end else if (pre_tick) begin
            act_q  <= pend_q;
            dcnt_q <= (hit || sel_change) ? '0 : dcnt_q + 1'b1;
        end
    end

    // Next-state logic of the mode machine.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            CH_DIVIDE:   if (pre_tick && EXT_CODES[pend_q])  mode_d = CH_EXTERNAL;
            CH_EXTERNAL: if (pre_tick && !EXT_CODES[pend_q]) mode_d = CH_DIVIDE;
            default:     mode_d = CH_DIVIDE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= CH_DIVIDE;
        else        mode_q <= mode_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            unique case (mode_q)
                CH_DIVIDE:   tick_q <= pre_tick && hit;
                CH_EXTERNAL: tick_q <= ext_edge;
                default:     tick_q <= 1'b0;
            endcase
        end
    end

    assign tick_o  = tick_q;
    assign is_ext  = (mode_q == CH_EXTERNAL);
    assign act_sel = act_q;

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_tick_pkg::*;
#(
    parameter int                  NUM_CH       = 5,
    parameter int                  GRP0_CH      = 2,
    parameter int                  PRE_W        = 8,
    parameter int                  SEL_W        = 4,
    parameter int                  DIV_BASE     = 0,
    parameter int                  MAX_DIV_CODE = 4,
    parameter logic [2**SEL_W-1:0] EXT_CODES    = 16'h00E0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              ext_clk_i,
    input  logic                    pre_wr,
    input  logic [2*PRE_W-1:0]      pre_wdata,
    input  logic                    sel_wr,
    input  logic [NUM_CH*SEL_W-1:0] sel_wdata,
    output logic [NUM_CH-1:0]       tick_o
);

    localparam int NUM_GRP = 2;

    logic [NUM_GRP-1:0]       pre_tick;
    logic [NUM_GRP-1:0]       ext_edge;
    logic [NUM_GRP*PRE_W-1:0] act_pre;
    logic [NUM_CH-1:0]        ch_ext;
    logic [NUM_CH*SEL_W-1:0]  act_sel;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (pre_wr),
            .wdata    (pre_wdata[g*PRE_W +: PRE_W]),
            .pre_tick (pre_tick[g]),
            .act_val  (act_pre[g*PRE_W +: PRE_W])
        );

        pwm_ext_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .ext_in (ext_clk_i[g]),
            .edge_o (ext_edge[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int G = grp_of(c, GRP0_CH);

        pwm_tick_channel #(
            .SEL_W        (SEL_W),
            .DIV_BASE     (DIV_BASE),
            .MAX_DIV_CODE (MAX_DIV_CODE),
            .EXT_CODES    (EXT_CODES)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (sel_wr),
            .wdata    (sel_wdata[c*SEL_W +: SEL_W]),
            .pre_tick (pre_tick[G]),
            .ext_edge (ext_edge[G]),
            .tick_o   (tick_o[c]),
            .is_ext   (ch_ext[c]),
            .act_sel  (act_sel[c*SEL_W +: SEL_W])
        );
    end

endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk
    import pwm_tick_pkg::*;
#(
    parameter int NUM_CH  = 5,
    parameter int GRP0_CH = 2,
    parameter int PRE_W   = 8,
    parameter int SEL_W   = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       tick_o,
    input logic [1:0]              pre_tick,
    input logic [2*PRE_W-1:0]      act_pre,
    input logic [NUM_CH-1:0]       ch_ext,
    input logic [NUM_CH*SEL_W-1:0] act_sel
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (tick_o == '0)
                else $error("tick asserted during reset");
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_grp
        p_pre_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !pre_tick[g] |=> $stable(act_pre[g*PRE_W +: PRE_W]));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int G = grp_of(c, GRP0_CH);

        p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !pre_tick[G] |=> $stable(act_sel[c*SEL_W +: SEL_W]));

        p_div_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_ext[c] && !pre_tick[G]) |=> !tick_o[c]);

        p_ext_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ext[c] && $past(ch_ext[c]) && tick_o[c]) |=> !tick_o[c]);
    end

endmodule

bind pwm_tick_gen pwm_tick_gen_chk #(
    .NUM_CH  (NUM_CH),
    .GRP0_CH (GRP0_CH),
    .PRE_W   (PRE_W),
    .SEL_W   (SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_o   (tick_o),
    .pre_tick (pre_tick),
    .act_pre  (act_pre),
    .ch_ext   (ch_ext),
    .act_sel  (act_sel)
);

// File: tb/pwm_tick_gen_test.sv
`timescale 1ns/1ps
module pwm_tick_gen_test;

    localparam int NCH  = 5;
    localparam int MAXC = 4;
    localparam int BASE = 0;
    localparam logic [15:0] EXTC = 16'h00E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_clk_i = 2'b00;
    logic        pre_wr = 1'b0;
    logic [15:0] pre_wdata = '0;
    logic        sel_wr = 1'b0;
    logic [19:0] sel_wdata = '0;
    logic [4:0]  tick_o;

    pwm_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i),
        .pre_wr(pre_wr), .pre_wdata(pre_wdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .tick_o(tick_o)
    );

    always #2.5 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;
    int    ext_half [2] = '{0, 0};
    int    ext_cnt [2] = '{0, 0};

    // Behavioural reference model.
    int   m_pend_p [2], m_act_p [2], m_pcnt [2];
    int   m_pend_s [NCH], m_act_s [NCH], m_dcnt [NCH];
    bit   m_h1 [2], m_h2 [2], m_h3 [2];
    logic [4:0] exp_tick = '0;

    always @(posedge clk) begin
        bit pt [2];
        bit ed [2];
        if (!rst_n) begin
            for (int g = 0; g < 2; g++) begin
                m_pend_p[g] = 0; m_act_p[g] = 0; m_pcnt[g] = 0;
                m_h1[g] = 0; m_h2[g] = 0; m_h3[g] = 0;
            end
            for (int c = 0; c < NCH; c++) begin
                m_pend_s[c] = 0; m_act_s[c] = 0; m_dcnt[c] = 0;
            end
            exp_tick = '0;
        end else begin
            for (int g = 0; g < 2; g++) begin
                pt[g] = (m_pcnt[g] == m_act_p[g]);
                ed[g] = m_h2[g] && !m_h3[g];
            end
            for (int c = 0; c < NCH; c++) begin
                int g, e, m, nw;
                bit hit;
                g = (c < 2) ? 0 : 1;
                e = ((m_act_s[c] > MAXC) ? MAXC : m_act_s[c]) + BASE;
                m = (1 << e) - 1;
                hit = ((m_dcnt[c] & m) == m);
                if (EXTC[m_act_s[c]]) exp_tick[c] = ed[g];
                else                  exp_tick[c] = pt[g] && hit;
                if (pt[g]) begin
                    nw = m_pend_s[c];
                    m_dcnt[c] = (hit || nw != m_act_s[c]) ? 0 : m_dcnt[c] + 1;
                    m_act_s[c] = nw;
                end
            end
            for (int g = 0; g < 2; g++) begin
                if (pt[g]) begin m_pcnt[g] = 0; m_act_p[g] = m_pend_p[g]; end
                else       m_pcnt[g] = m_pcnt[g] + 1;
                m_h3[g] = m_h2[g]; m_h2[g] = m_h1[g]; m_h1[g] = ext_clk_i[g];
                if (pre_wr) m_pend_p[g] = int'(pre_wdata[g*8 +: 8]);
            end
            if (sel_wr)
                for (int c = 0; c < NCH; c++) m_pend_s[c] = int'(sel_wdata[c*4 +: 4]);
        end
    end

    task automatic step();
        @(negedge clk);
        n_cmp++;
        if (tick_o !== exp_tick) begin
            n_bad++;
            $display("FAIL %s: tick_o actual %b expected %b at %0t", cur_req, tick_o, exp_tick, $time);
        end
        for (int g = 0; g < 2; g++) begin
            if (ext_half[g] != 0) begin
                ext_cnt[g]++;
                if (ext_cnt[g] >= ext_half[g]) begin
                    ext_cnt[g] = 0;
                    ext_clk_i[g] = ~ext_clk_i[g];
                end
            end
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr_pre(input logic [7:0] p1, input logic [7:0] p0);
        pre_wr = 1'b1; pre_wdata = {p1, p0};
        step();
        pre_wr = 1'b0;
    endtask

    task automatic wr_sel(input logic [3:0] s4, input logic [3:0] s3, input logic [3:0] s2,
                          input logic [3:0] s1, input logic [3:0] s0);
        sel_wr = 1'b1; sel_wdata = {s4, s3, s2, s1, s0};
        step();
        sel_wr = 1'b0;
    endtask

    initial begin
        // R1: reset quiet, then full-rate ticks with zeroed fields
        cur_req = "R1";
        run(6);
        rst_n = 1'b1;
        run(20);
        // R2: prescale fields, one per group
        cur_req = "R2";
        wr_pre(8'd5, 8'd2);
        run(60);
        // R4 / R5 / R3: distinct codes per channel, groups on separate prescalers
        cur_req = "R4_R5_R3";
        wr_sel(4'd4, 4'd2, 4'd0, 4'd3, 4'd1);
        run(300);
        // R6: codes above the divide range clamp
        cur_req = "R6";
        wr_sel(4'd15, 4'd12, 4'd8, 4'd4, 4'd9);
        run(250);
        // R7 / R3: external clocks with coprime half-periods
        cur_req = "R7_R3";
        ext_half[0] = 7; ext_half[1] = 11;
        wr_sel(4'd7, 4'd1, 4'd6, 4'd0, 4'd5);
        run(400);
        // R8: long periods, writes mid-period and changes of mode
        cur_req = "R8";
        wr_pre(8'd30, 8'd20);
        run(9);
        wr_sel(4'd2, 4'd5, 4'd1, 4'd6, 4'd3);
        run(17);
        wr_sel(4'd0, 4'd7, 4'd3, 4'd2, 4'd5);
        run(200);
        wr_pre(8'd1, 8'd0);
        wr_sel(4'd1, 4'd2, 4'd0, 4'd1, 4'd2);
        run(150);
        ext_half[0] = 1;
        wr_sel(4'd0, 4'd0, 4'd0, 4'd6, 4'd5);
        run(120);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule